// File: doc/BRIEF.md
# Virtual Supervisor Timer Interrupt Alias Unit

This block holds the supervisor-timer slice of a hypervisor-capable core's interrupt state. A hypervisor pending bit is formed from a software-settable injection bit ORed with a VS-level timer compare input. A hypervisor enable bit masks it. A delegation bit decides whether the guest's own view of these bits is live or forced to zero. The same delegation bit also decides which privilege level takes the resulting interrupt.

Software reaches the bits through one write port and one read port. Each port is indexed by a 3-bit selector and carries only the single modelled bit. While the core runs a guest (virtualization flag high), accesses to the ordinary supervisor timer enable are steered onto the guest view. In host mode that enable keeps a storage bit of its own. A registered one-cycle trap request marks each new arrival of an enabled pending interrupt. It comes with a target flag: 0 means host supervisor, 1 means guest supervisor.

Top module: `vs_timer_irq_alias`

Selector encoding, used by both ports:

| Selector | Name | Access |
|---|---|---|
| 0 | host enable | read and write |
| 1 | injection | read and write |
| 2 | delegation | read and write |
| 3 | supervisor enable, redirected when the virtualization flag is high | read and write |
| 4 | guest enable | read and write |
| 5 | guest pending | read-only |
| 6 | host pending | read-only |
| 7 | unused | reads 0 |

## Requirements
- R1: While delegation is 0, reads of selector 4 (guest enable) and selector 5 (guest pending) return 0. A write to selector 4 leaves the host enable bit unchanged.
- R2: While delegation is 1, selector 4 reads the host enable bit and a write to selector 4 updates it. Selector 5 reads the host pending bit.
- R3: The host pending bit (output `hip_vstip_o`, selector 6) equals the injection bit ORed with `vs_tmr_i`. It follows `vs_tmr_i` in the same cycle.
- R4: Writes to selector 5 and selector 6 change no state.
- R5: With `virt_i` at 0, selector 3 reads and writes a separate supervisor enable bit (output `sie_stie_o`). With `virt_i` at 1, selector 3 acts exactly like selector 4 and leaves that separate bit untouched.
- R6: Writing the delegation bit never changes the host enable bit.
- R7: `trap_req_o` goes high for exactly one cycle, on the clock edge after pending AND host enable changes from 0 to 1.
- R8: `trap_vs_o` is valid while `trap_req_o` is high. It is 1 when delegation was 1 in the cycle the condition arose, and 0 when delegation was 0 (host target).
- R9: After reset, the host enable, injection, delegation and supervisor enable bits are 0, and `trap_req_o` is 0.
- R10: Selector 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| virt_i | input | 1 | Guest execution flag; redirects selector 3 |
| vs_tmr_i | input | 1 | VS-level timer compare input |
| csr_we_i | input | 1 | Write strobe |
| csr_wsel_i | input | 3 | Write selector |
| csr_wbit_i | input | 1 | Written bit value |
| csr_rsel_i | input | 3 | Read selector |
| csr_rbit_o | output | 1 | Read bit value, combinational |
| hip_vstip_o | output | 1 | Host pending bit |
| hie_vstie_o | output | 1 | Host enable bit |
| deleg_o | output | 1 | Delegation bit |
| sie_stie_o | output | 1 | Separate supervisor enable bit |
| trap_req_o | output | 1 | One-cycle trap request |
| trap_vs_o | output | 1 | Trap target: 0 host, 1 guest |

## Verification
The assertions check the following on every cycle:
- the one-cycle shape of the trap request and its link to a newly enabled pending interrupt;
- the target flag it carries;
- that a guest-enable write has no effect while the bit is not delegated;
- that a delegation write leaves the host enable bit alone;
- that a read-only write leaves the pending bit alone.

The aliasing map needs the bench's sweep to show it. The sweep covers every combination of delegation, virtualization flag, stored bits and timer input, and checks every selector's read. The trap scenarios also depend on the bench, including the re-arming after the condition drops and the target flipping with delegation.

// File: rtl/vs_timer_irq_alias.sv
module vs_timer_irq_alias (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       virt_i,
  input  logic       vs_tmr_i,
  input  logic       csr_we_i,
  input  logic [2:0] csr_wsel_i,
  input  logic       csr_wbit_i,
  input  logic [2:0] csr_rsel_i,
  output logic       csr_rbit_o,
  output logic       hip_vstip_o,
  output logic       hie_vstie_o,
  output logic       deleg_o,
  output logic       sie_stie_o,
  output logic       trap_req_o,
  output logic       trap_vs_o
);
  localparam logic [2:0] SEL_HEN  = 3'd0;
  localparam logic [2:0] SEL_INJ  = 3'd1;
  localparam logic [2:0] SEL_DLG  = 3'd2;
  localparam logic [2:0] SEL_SEN  = 3'd3;
  localparam logic [2:0] SEL_GEN  = 3'd4;
  localparam logic [2:0] SEL_GPND = 3'd5;
  localparam logic [2:0] SEL_HPND = 3'd6;

  logic hen_q, inj_q, dlg_q, sen_q, hit_q;
  logic wr_guest_en, pend, hit;

  assign pend = inj_q | vs_tmr_i;
  assign hit  = pend & hen_q;

  assign wr_guest_en = csr_we_i &&
                       (csr_wsel_i == SEL_GEN || (csr_wsel_i == SEL_SEN && virt_i));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hen_q      <= 1'b0;
      inj_q      <= 1'b0;
      dlg_q      <= 1'b0;
      sen_q      <= 1'b0;
      hit_q      <= 1'b0;
      trap_req_o <= 1'b0;
      trap_vs_o  <= 1'b0;
    end else begin
      if (csr_we_i && csr_wsel_i == SEL_HEN) hen_q <= csr_wbit_i;
      if (wr_guest_en && dlg_q)              hen_q <= csr_wbit_i;
      if (csr_we_i && csr_wsel_i == SEL_INJ) inj_q <= csr_wbit_i;
      if (csr_we_i && csr_wsel_i == SEL_DLG) dlg_q <= csr_wbit_i;
      if (csr_we_i && csr_wsel_i == SEL_SEN && !virt_i) sen_q <= csr_wbit_i;
      hit_q      <= hit;
      trap_req_o <= hit & ~hit_q;
      trap_vs_o  <= dlg_q;
    end
  end

  always_comb begin
    unique case (csr_rsel_i)
      SEL_HEN:  csr_rbit_o = hen_q;
      SEL_INJ:  csr_rbit_o = inj_q;
      SEL_DLG:  csr_rbit_o = dlg_q;
      SEL_SEN:  csr_rbit_o = virt_i ? (dlg_q & hen_q) : sen_q;
      SEL_GEN:  csr_rbit_o = dlg_q & hen_q;
      SEL_GPND: csr_rbit_o = dlg_q & pend;
      SEL_HPND: csr_rbit_o = pend;
      default:  csr_rbit_o = 1'b0;
    endcase
  end

  assign hip_vstip_o = pend;
  assign hie_vstie_o = hen_q;
  assign deleg_o     = dlg_q;
  assign sie_stie_o  = sen_q;

  // R1
  guest_wr_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we_i && csr_wsel_i == SEL_GEN && !deleg_o) |=> $stable(hie_vstie_o));

  // R6
  deleg_keeps_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we_i && csr_wsel_i == SEL_DLG) |=> $stable(hie_vstie_o));

  // R4
  ro_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we_i && (csr_wsel_i == SEL_GPND || csr_wsel_i == SEL_HPND) && !vs_tmr_i)
      |=> (hip_vstip_o == $past(hip_vstip_o)) || vs_tmr_i);

  // R7
  trap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req_o |=> !trap_req_o);

  // R7
  trap_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trap_req_o) |-> $past(hip_vstip_o && hie_vstie_o));

  // R8
  trap_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req_o |-> trap_vs_o == $past(deleg_o));
endmodule

// File: tb/tb_vs_timer_irq_alias.sv
module tb_vs_timer_irq_alias;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic virt_i = 1'b0, vs_tmr_i = 1'b0, csr_we_i = 1'b0, csr_wbit_i = 1'b0;
  logic [2:0] csr_wsel_i = 3'd0, csr_rsel_i = 3'd0;
  logic csr_rbit_o, hip_vstip_o, hie_vstie_o, deleg_o, sie_stie_o, trap_req_o, trap_vs_o;

  int total = 0, bad = 0;
  bit finished = 1'b0;
  logic m_hen, m_inj, m_dlg, m_sen;

  always #4 clk = ~clk;

  vs_timer_irq_alias dut (.*);

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic val);
    @(negedge clk);
    csr_we_i = 1'b1; csr_wsel_i = sel; csr_wbit_i = val;
    @(negedge clk);
    csr_we_i = 1'b0;
    case (sel)
      3'd0: m_hen = val;
      3'd1: m_inj = val;
      3'd2: m_dlg = val;
      3'd3: if (virt_i) begin if (m_dlg) m_hen = val; end else m_sen = val;
      3'd4: if (m_dlg) m_hen = val;
      default: ;
    endcase
  endtask

  function automatic logic exp_rd(input int sel);
    logic p = m_inj | vs_tmr_i;
    case (sel)
      0: return m_hen;
      1: return m_inj;
      2: return m_dlg;
      3: return virt_i ? (m_dlg & m_hen) : m_sen;
      4: return m_dlg & m_hen;
      5: return m_dlg & p;
      6: return p;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string req_of(input int sel);
    case (sel)
      3: return "R5";
      4, 5: return "R1/R2";
      6: return "R3";
      7: return "R10";
      default: return "R2";
    endcase
  endfunction

  task automatic check_reads();
    for (int s = 0; s < 8; s++) begin
      csr_rsel_i = s[2:0];
      #1;
      chk(req_of(s), csr_rbit_o, exp_rd(s), $sformatf("read sel=%0d", s));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_hen = 0; m_inj = 0; m_dlg = 0; m_sen = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9", hie_vstie_o, 1'b0, "host enable after reset");
    chk("R9", deleg_o, 1'b0, "delegation after reset");
    chk("R9", sie_stie_o, 1'b0, "sup enable after reset");
    chk("R9", hip_vstip_o, 1'b0, "pending after reset");
    chk("R9", trap_req_o, 1'b0, "trap after reset");
    check_reads();

    // Sweep: R1 R2 R3 R4 R5 R10
    for (int k = 0; k < 64; k++) begin
      virt_i = 1'b0;
      wr(3'd2, k[0]);
      wr(3'd0, k[1]);
      wr(3'd1, k[2]);
      wr(3'd3, k[3]);
      virt_i = k[4];
      vs_tmr_i = k[5];
      check_reads();
      chk("R3", hip_vstip_o, k[2] | k[5], "pending port");
      // R1/R2 guest-enable write toggles only when delegated
      wr(3'd4, ~m_hen);
      chk("R1/R2", hie_vstie_o, m_hen, "host enable after guest write");
      // R5 redirected write
      wr(3'd3, ~(virt_i ? m_hen : m_sen));
      chk("R5", sie_stie_o, m_sen, "sup enable after sel3 write");
      chk("R5", hie_vstie_o, m_hen, "host enable after sel3 write");
      // R4 read-only writes
      wr(3'd5, ~m_inj);
      wr(3'd6, ~m_inj);
      chk("R4", hip_vstip_o, m_inj | vs_tmr_i, "pending after ro write");
      chk("R4", hie_vstie_o, m_hen, "enable after ro write");
      // R6 delegation writes keep enable
      wr(3'd2, ~m_dlg);
      chk("R6", hie_vstie_o, m_hen, "enable after delegation toggle");
      check_reads();
    end

    // Trap scenarios R7 R8
    virt_i = 1'b0; vs_tmr_i = 1'b0;
    wr(3'd1, 1'b0); wr(3'd2, 1'b1); wr(3'd0, 1'b1);
    repeat (2) @(negedge clk);
    chk("R7", trap_req_o, 1'b0, "idle no trap");
    vs_tmr_i = 1'b1;
    #1 chk("R7", trap_req_o, 1'b0, "trap not same cycle");
    @(negedge clk);
    chk("R7", trap_req_o, 1'b1, "trap after one edge");
    chk("R8", trap_vs_o, 1'b1, "guest target");
    @(negedge clk);
    chk("R7", trap_req_o, 1'b0, "trap single cycle");
    repeat (3) @(negedge clk);
    chk("R7", trap_req_o, 1'b0, "no retrigger while held");
    vs_tmr_i = 1'b0;
    @(negedge clk);
    wr(3'd2, 1'b0);
    chk("R6", hie_vstie_o, 1'b1, "enable kept after undelegate");
    csr_rsel_i = 3'd4; #1 chk("R1", csr_rbit_o, 1'b0, "guest enable hidden");
    vs_tmr_i = 1'b1;
    @(negedge clk);
    chk("R7", trap_req_o, 1'b1, "rearmed trap");
    chk("R8", trap_vs_o, 1'b0, "host target");
    @(negedge clk);
    chk("R7", trap_req_o, 1'b0, "rearmed single cycle");
    // enable rising with pending already high
    wr(3'd0, 1'b0);
    wr(3'd0, 1'b1);
    chk("R7", trap_req_o, 1'b0, "trap not yet after enable write");
    @(negedge clk);
    chk("R7", trap_req_o, 1'b1, "trap from enable rise");
    chk("R8", trap_vs_o, 1'b0, "host target on enable rise");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule